// File: doc/BRIEF.md
# Thread Interrupt Presentation Context

This block is the presentation point between an interrupt source fabric and one hardware thread. Sources post a priority into an eight-entry pending buffer. The thread sets its own acceptance level, and the block raises an exception output only while the most urgent pending priority is numerically below that level. A separate level-sensitive line, fixed at one priority, competes with the pending buffer for the exception output.

Software sees the state through a small memory-mapped port with a one-cycle read latency. One read address is the acknowledge operation. It returns the kind of exception and the priority being taken. As a side effect it raises the acceptance level to that priority, and for a posted interrupt it also clears the matching pending bit.

A pool context word carries a valid flag in bit 31 and an identifier in the low bits. Software can load it, read it, and pull it back with one atomic read that also invalidates it.

Top module: `irq_thread_ctx`

## Requirements
- R1: After reset the acceptance level is 0x00, the pending buffer is empty, the pool word is zero, and the exception output is low with kind 0.
- R2: A pulse on post_vld sets bit post_prio of the pending buffer, which reads at offset 0x32 (bit n is priority n). Offset 0x37 reads the lowest set priority, or 0xFF when the buffer is empty.
- R3: A posted priority raises the exception with kind 2 only while the lowest pending priority is numerically below the acceptance level. excp_o and excp_kind change on the edge that changes the state. Offset 0x30 reads the current kind in bits 7:6.
- R4: A read at 0x800 is the acknowledge. It returns the kind in bits 15:14 and the acknowledged priority in bits 7:0, with every other bit zero. The kind codes are 0 none, 1 pool (never produced), 2 posted and 3 level. For kind 2 the read clears that pending bit and sets the acceptance level to the acknowledged priority.
- R5: While lvl_line is high and LVL_PRIO is below the acceptance level, the level line is signalled with kind 3. It is preferred over a posted priority that is not more urgent. Acknowledging it sets the acceptance level to LVL_PRIO and leaves the pending buffer unchanged.
- R6: An acknowledge with nothing signalled returns kind 0 with the current acceptance level in the low byte, and it changes no state.
- R7: A write at offset 0x31 loads the acceptance level from wdata[7:0], and a read at 0x31 returns it. The value 0xFF admits every priority.
- R8: Offset 0x28 holds the 32-bit pool word. It is written from wdata[31:0] and read back zero-extended, and bit 31 is its valid flag.
- R9: A read at 0x828 returns the pool word and clears its bit 31 in the same operation. The other bits are kept.
- R10: When a post and an acknowledge name the same priority in the same cycle, the post wins and the pending bit stays set.
- R11: Every other offset, including the guest set at 0x10 to 0x1F, reads as zero. Writes to those offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post a priority this cycle |
| post_prio | input | PRIO_W | Priority being posted |
| lvl_line | input | 1 | Level-sensitive interrupt line |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 64 | Write data, right-justified |
| rdata | output | 64 | Read data, valid the cycle after rd_en |
| excp_o | output | 1 | Exception pending toward the thread |
| excp_kind | output | 2 | Kind of the pending exception |

## Verification
The bench builds the block with PRIO_W of 3, which gives the full eight-entry buffer, and with LVL_PRIO lowered from its default of 7 to 4. The lower level priority lets a posted priority land on either side of the level line. That brings both outcomes of the level-versus-posted preference into reach, as well as a level acknowledge that leaves a less urgent posted priority masked. The same-cycle post and acknowledge collision and the double pull of the pool word are driven as their own scenarios.

// File: rtl/irq_thread_ctx_pkg.sv
package irq_thread_ctx_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_POOL  = 2'd1,
    KIND_POST  = 2'd2,
    KIND_LEVEL = 2'd3
  } exc_kind_e;

  // register set bases
  localparam int unsigned GUEST_BASE = 32'h010;
  localparam int unsigned POOL_BASE  = 32'h020;
  localparam int unsigned PHYS_BASE  = 32'h030;

  // byte offsets inside a set
  localparam int unsigned OFF_STATUS = 32'h0;
  localparam int unsigned OFF_ACCEPT = 32'h1;
  localparam int unsigned OFF_PEND   = 32'h2;
  localparam int unsigned OFF_TOP    = 32'h7;
  localparam int unsigned OFF_WORD2  = 32'h8;

  // special operations
  localparam int unsigned ACK_ADDR   = 32'h800;
  localparam int unsigned PULL_ADDR  = 32'h828;

  localparam int unsigned DATA_W     = 64;
  localparam logic [7:0]  PRIO_EMPTY = 8'hFF;

endpackage

// File: rtl/irq_thread_ctx_prio.sv
module irq_thread_ctx_prio #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] vec,
  output logic [7:0]   top,
  output logic         any
);
  always_comb begin
    top = 8'hFF;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        top = 8'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_thread_ctx_pool.sv
module irq_thread_ctx_pool #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         pull,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (load) begin
      word <= load_val;
    end else if (pull) begin
      word[W-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_thread_ctx.sv
module irq_thread_ctx
  import irq_thread_ctx_pkg::*;
#(
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned LVL_PRIO = 7,
  parameter int unsigned POOL_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_vld,
  input  logic [PRIO_W-1:0] post_prio,
  input  logic              lvl_line,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  output logic              excp_o,
  output logic [1:0]        excp_kind
);
  localparam int unsigned NPRIO = 1 << PRIO_W;
  localparam logic [7:0]  LVL8  = 8'(LVL_PRIO);

  logic [NPRIO-1:0] pend_q, pend_d, post_set, ack_clr;
  logic [7:0]       accept_q, accept_d, top_q, top_d, ack_prio;
  logic             any_q, any_d;
  exc_kind_e        kind_now, kind_d;
  logic [1:0]       kind_q;
  logic             excp_q;
  logic [63:0]      rdata_q, rmux;
  logic [POOL_W-1:0] pool_word;
  logic             is_ack, is_pull, wr_accept, wr_pool;

  function automatic exc_kind_e pick_kind(input logic [7:0] top, input logic any,
                                          input logic [7:0] acc, input logic lvl);
    logic ph, lv;
    ph = any && (top < acc);
    lv = lvl && (LVL8 < acc);
    if (lv && (!ph || LVL8 <= top)) return KIND_LEVEL;
    else if (ph)                    return KIND_POST;
    else                            return KIND_NONE;
  endfunction

  irq_thread_ctx_prio #(.N(NPRIO)) u_prio_cur (.vec(pend_q), .top(top_q), .any(any_q));
  irq_thread_ctx_prio #(.N(NPRIO)) u_prio_nxt (.vec(pend_d), .top(top_d), .any(any_d));

  irq_thread_ctx_pool #(.W(POOL_W)) u_pool (
    .clk(clk), .rst(rst), .load(wr_pool), .load_val(wdata[POOL_W-1:0]),
    .pull(is_pull), .word(pool_word)
  );

  assign is_ack    = rd_en && (addr == ADDR_W'(ACK_ADDR));
  assign is_pull   = rd_en && (addr == ADDR_W'(PULL_ADDR));
  assign wr_accept = wr_en && (addr == ADDR_W'(PHYS_BASE + OFF_ACCEPT));
  assign wr_pool   = wr_en && (addr == ADDR_W'(POOL_BASE + OFF_WORD2));

  assign kind_now = pick_kind(top_q, any_q, accept_q, lvl_line);

  always_comb begin
    case (kind_now)
      KIND_POST:  ack_prio = top_q;
      KIND_LEVEL: ack_prio = LVL8;
      default:    ack_prio = accept_q;
    endcase
  end

  always_comb begin
    post_set = '0;
    ack_clr  = '0;
    if (post_vld) post_set[post_prio] = 1'b1;
    if (is_ack && kind_now == KIND_POST) ack_clr[top_q[PRIO_W-1:0]] = 1'b1;
    pend_d = (pend_q & ~ack_clr) | post_set;
  end

  always_comb begin
    if (wr_accept)                          accept_d = wdata[7:0];
    else if (is_ack && kind_now != KIND_NONE) accept_d = ack_prio;
    else                                    accept_d = accept_q;
  end

  assign kind_d = pick_kind(top_d, any_d, accept_d, lvl_line);

  always_comb begin
    rmux = '0;
    if (addr == ADDR_W'(ACK_ADDR))
      rmux[15:0] = {kind_now, 6'b0, ack_prio};
    else if (addr == ADDR_W'(PULL_ADDR) || addr == ADDR_W'(POOL_BASE + OFF_WORD2))
      rmux[POOL_W-1:0] = pool_word;
    else if (addr == ADDR_W'(PHYS_BASE + OFF_STATUS))
      rmux[7:0] = {kind_now, 6'b0};
    else if (addr == ADDR_W'(PHYS_BASE + OFF_ACCEPT))
      rmux[7:0] = accept_q;
    else if (addr == ADDR_W'(PHYS_BASE + OFF_PEND))
      rmux[NPRIO-1:0] = pend_q;
    else if (addr == ADDR_W'(PHYS_BASE + OFF_TOP))
      rmux[7:0] = top_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      accept_q <= 8'h00;
      kind_q   <= KIND_NONE;
      excp_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      pend_q   <= pend_d;
      accept_q <= accept_d;
      kind_q   <= kind_d;
      excp_q   <= (kind_d != KIND_NONE);
      if (rd_en) rdata_q <= rmux;
    end
  end

  assign rdata     = rdata_q;
  assign excp_o    = excp_q;
  assign excp_kind = kind_q;

endmodule

// File: rtl/irq_thread_ctx_chk.sv
module irq_thread_ctx_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [63:0]       rdata,
  input logic              excp_o,
  input logic [1:0]        excp_kind,
  input logic [7:0]        accept,
  input logic [7:0]        top,
  input logic              pool_valid
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (accept == 8'h00 && !excp_o && excp_kind == 2'd0)); // R1

  AST_FLAG_KIND: assert property (@(posedge clk) disable iff (rst)
    excp_o == (excp_kind != 2'd0)); // R3

  AST_POST_GATED: assert property (@(posedge clk) disable iff (rst)
    (excp_kind == 2'd2) |-> (top < accept)); // R3

  AST_ACK_FORMAT: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == ADDR_W'(12'h800)) |-> (rdata[63:16] == '0 && rdata[13:8] == '0)); // R4

  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en && !wr_en && addr == ADDR_W'(12'h800)) && rdata[15:14] != 2'd0)
      |-> (accept == rdata[7:0])); // R4

  AST_PULL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !wr_en && addr == ADDR_W'(12'h828)) |-> !pool_valid); // R9
endmodule

bind irq_thread_ctx irq_thread_ctx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .excp_o(excp_o), .excp_kind(excp_kind),
  .accept(accept_q), .top(top_q), .pool_valid(pool_word[POOL_W-1])
);

// File: tb/irq_thread_ctx_tb.sv
module irq_thread_ctx_tb;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              post_vld = 1'b0;
  logic [PRIO_W-1:0] post_prio = '0;
  logic              lvl_line = 1'b0;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [63:0]       wdata = '0;
  logic [63:0]       rdata;
  logic              excp_o;
  logic [1:0]        excp_kind;

  int checks = 0;
  int errors = 0;
  logic [63:0] d;

  always #5 clk = ~clk;

  irq_thread_ctx #(.PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .LVL_PRIO(4), .POOL_W(32)) u_dut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_prio(post_prio),
    .lvl_line(lvl_line), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .excp_o(excp_o), .excp_kind(excp_kind)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic post(input logic [PRIO_W-1:0] p);
    @(negedge clk); post_vld = 1'b1; post_prio = p;
    @(negedge clk); post_vld = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 excp", {63'b0, excp_o}, 64'd0);
    check("R1 kind", {62'b0, excp_kind}, 64'd0);
    rd(12'h031, d); check("R1 accept", d, 64'h00);
    rd(12'h037, d); check("R2 top empty", d, 64'hFF);
    rd(12'h028, d); check("R1 pool", d, 64'h0);
  endtask

  task automatic t_gate();
    post(3'd5);
    check("R3 masked at level 0", {63'b0, excp_o}, 64'd0);
    rd(12'h032, d); check("R2 pend vec", d, 64'h20);
    rd(12'h037, d); check("R2 top", d, 64'h05);
    wr(12'h031, 64'hFF);
    check("R7 open level raises", {62'b0, excp_kind}, 64'd2);
    rd(12'h031, d); check("R7 readback", d, 64'hFF);
    rd(12'h030, d); check("R3 status byte", d, 64'h80);
  endtask

  task automatic t_ack();
    post(3'd2);
    rd(12'h800, d); check("R4 ack 2", d, 64'h8002);
    check("R4 masked after ack", {63'b0, excp_o}, 64'd0);
    rd(12'h032, d); check("R4 bit cleared", d, 64'h20);
    wr(12'h031, 64'h06);
    check("R3 5 below 6", {63'b0, excp_o}, 64'd1);
    rd(12'h800, d); check("R4 ack 5", d, 64'h8005);
    rd(12'h037, d); check("R4 empty after", d, 64'hFF);
  endtask

  task automatic t_none();
    rd(12'h800, d); check("R6 ack none", d, 64'h0005);
    rd(12'h031, d); check("R6 level kept", d, 64'h05);
  endtask

  task automatic t_level();
    wr(12'h031, 64'hFF);
    @(negedge clk); lvl_line = 1'b1;
    @(negedge clk);
    check("R5 level kind", {62'b0, excp_kind}, 64'd3);
    post(3'd6);
    check("R5 level preferred", {62'b0, excp_kind}, 64'd3);
    rd(12'h800, d); check("R5 ack level", d, 64'hC004);
    check("R5 masked", {63'b0, excp_o}, 64'd0);
    rd(12'h032, d); check("R5 pend kept", d, 64'h40);
    wr(12'h031, 64'hFF);
    post(3'd1);
    check("R5 post more urgent", {62'b0, excp_kind}, 64'd2);
    rd(12'h800, d); check("R5 ack post 1", d, 64'h8001);
    @(negedge clk); lvl_line = 1'b0;
    wr(12'h031, 64'hFF);
    rd(12'h800, d); check("R4 ack 6", d, 64'h8006);
  endtask

  task automatic t_collide();
    wr(12'h031, 64'hFF);
    post(3'd3);
    @(negedge clk); post_vld = 1'b1; post_prio = 3'd3; rd_en = 1'b1; addr = 12'h800;
    @(negedge clk); post_vld = 1'b0; rd_en = 1'b0; d = rdata;
    check("R10 ack value", d, 64'h8003);
    check("R10 masked", {63'b0, excp_o}, 64'd0);
    rd(12'h032, d); check("R10 post wins", d, 64'h08);
    wr(12'h031, 64'hFF);
    rd(12'h800, d); check("R10 cleanup", d, 64'h8003);
  endtask

  task automatic t_pool();
    wr(12'h028, 64'h8000_00A5);
    rd(12'h028, d); check("R8 word", d, 64'h8000_00A5);
    rd(12'h828, d); check("R9 pull value", d, 64'h8000_00A5);
    rd(12'h028, d); check("R9 valid cleared", d, 64'h0000_00A5);
    rd(12'h828, d); check("R9 second pull", d, 64'h0000_00A5);
  endtask

  task automatic t_unmapped();
    wr(12'h011, 64'hFF);
    rd(12'h031, d); check("R11 guest write ignored", d, 64'h03);
    rd(12'h011, d); check("R11 guest read zero", d, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_ack();
    t_none();
    t_level();
    t_collide();
    t_pool();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule